// File: doc/BRIEF.md
# Flash Device Bus-Mode Controller

This block is the control front end of an asynchronous parallel NOR-style flash device that sits on a plain processor bus. It samples the chip-select, output-enable, write-enable and reset/power-down pins on a core clock. From them it decides when the data bus may be driven, and it keeps a read-mode register that bus write commands change. In the array read mode the byte comes from a synchronous memory port with one cycle of read latency. In the identifier mode a fixed manufacturer or device code is returned. In the status mode the status byte is returned, with bit 7 as the ready flag.

An embedded erase or program operation is represented only by a busy timer. A setup command followed by one data write starts the timer, and the ready/busy pin stays low until the timer expires. Holding the reset/power-down pin low for long enough puts the device into deep power-down. Entry aborts any running operation, forces the array read mode and sets the status byte back to 80h. After the pin is released, a timed wake-up window must pass before the bus is driven again or commands are taken.

Top module: `flash_bus_ctrl`

## Requirements
- R1: After `rst_n` is released the mode is array read, the status byte is 80h, `ready` is 1 and `bus_drive` is 0 while the device is deselected.
- R2: A command is taken on the clock edge that first samples `we_n` high after it was low, provided `ce_n` is low at that edge. Byte FFh selects array read, 90h selects identifier read and 70h selects status read. A write-enable pulse with `ce_n` high changes nothing.
- R3: `bus_drive` is 1 only when `ce_n`=0, `oe_n`=0, `we_n`=1, `pd_n`=1 and the device is awake. `dout` is 00h whenever `bus_drive` is 0.
- R4: In array read mode, `dout` equals `mem_rdata`, and `mem_addr` follows `addr`. The memory returns data one cycle after the address.
- R5: In identifier mode, `dout` is `MFR_CODE` (default 5Ch) at address 0, `DEV_CODE` (default 3Eh) at address 1, and 00h at any other address.
- R6: In status mode, `dout` is the status byte. Bit 7 is the ready flag and bits 6..0 read 0.
- R7: Command 40h followed by any data write starts an operation. Status bit 7 clears, the mode switches to status read, and `ready` stays low for exactly `BUSY_CYCLES` cycles. Deselecting the device does not stop the operation. A 40h command written while busy is ignored.
- R8: When `pd_n` is low for `MIN_PD` consecutive samples, deep power-down is entered. Entry aborts any running operation, forces array read mode and sets the status byte to 80h. A shorter low pulse leaves the mode and any running operation untouched.
- R9: The first clock edge that samples `pd_n` high after power-down starts a wake window. The device becomes awake `WAKE_CYCLES` edges later. During the window the bus is not driven and commands are ignored. If an operation was aborted, `ready` stays low until the window ends.
- R10: A command byte other than FFh, 90h, 70h or 40h leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Power-up reset, active low |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; commands are taken on its rising edge |
| pd_n | input | 1 | Reset/deep power-down pin, active low |
| addr | input | AW | Bus address |
| din | input | 8 | Bus write data |
| dout | output | 8 | Read data, 00h when not driven |
| bus_drive | output | 1 | Output-driver enable for the data bus |
| ready | output | 1 | Ready (1) / busy (0) |
| mem_addr | output | AW | Address to the array memory |
| mem_rdata | input | 8 | Array data, one cycle after `mem_addr` |

## Verification
The bench aims first at the power-down pulse threshold. A pulse one sample short of `MIN_PD` must leave a running operation and the status mode in place. A pulse of exactly `MIN_PD` samples must return the device to array mode, so a counter that is off by one either ignores a valid reset or lets a glitch abort a program. The busy and wake windows are measured edge by edge. Being one cycle off either way shows up as `ready` or `bus_drive` changing a cycle early or late. A 90h command issued during the wake window, and a 40h plus data pair issued during a busy period, must both be dropped. A design that accepts them would come back in identifier mode or start a second busy period.

// File: rtl/flash_bus_ctrl.sv
module flash_bus_ctrl #(
  parameter int AW          = 20,
  parameter int MIN_PD      = 5,
  parameter int WAKE_CYCLES = 8,
  parameter int BUSY_CYCLES = 20,
  parameter logic [7:0] MFR_CODE = 8'h5C,
  parameter logic [7:0] DEV_CODE = 8'h3E
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          pd_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic          bus_drive,
  output logic          ready,
  output logic [AW-1:0] mem_addr,
  input  logic [7:0]    mem_rdata
);

  localparam int PW = $clog2(MIN_PD + 1);
  localparam int WW = $clog2(WAKE_CYCLES + 1);
  localparam int BW = $clog2(BUSY_CYCLES + 1);

  typedef enum logic [1:0] {ST_ACT, ST_PD, ST_WAKE} pstate_t;
  typedef enum logic [1:0] {M_ARRAY, M_ID, M_STAT} mode_t;

  pstate_t        st;
  mode_t          mode;
  logic           we_q, armed, op_busy, abort_pend, stat_rdy;
  logic [PW-1:0]  pd_cnt;
  logic [WW-1:0]  wcnt;
  logic [BW-1:0]  bcnt;
  logic [7:0]     rd_byte;

  wire pd_enter = !pd_n && (pd_cnt == PW'(MIN_PD - 1)) && (st != ST_PD);
  wire cmd_ok   = we_n && !we_q && !ce_n && pd_n && (st == ST_ACT);

  assign mem_addr  = addr;
  assign ready     = !op_busy && !abort_pend;
  assign bus_drive = !ce_n && !oe_n && we_n && pd_n && (st == ST_ACT);

  always_comb begin
    case (mode)
      M_ID:    rd_byte = (addr == AW'(0)) ? MFR_CODE :
                         (addr == AW'(1)) ? DEV_CODE : 8'h00;
      M_STAT:  rd_byte = {stat_rdy, 7'b0};
      default: rd_byte = mem_rdata;
    endcase
  end

  assign dout = bus_drive ? rd_byte : 8'h00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_ACT;
      mode       <= M_ARRAY;
      we_q       <= 1'b1;
      armed      <= 1'b0;
      op_busy    <= 1'b0;
      abort_pend <= 1'b0;
      stat_rdy   <= 1'b1;
      pd_cnt     <= '0;
      wcnt       <= '0;
      bcnt       <= '0;
    end else begin
      we_q <= we_n;
      if (pd_n)                          pd_cnt <= '0;
      else if (pd_cnt != PW'(MIN_PD))    pd_cnt <= pd_cnt + 1'b1;

      if (pd_enter) begin
        st         <= ST_PD;
        mode       <= M_ARRAY;
        stat_rdy   <= 1'b1;
        abort_pend <= abort_pend || op_busy;
        op_busy    <= 1'b0;
        armed      <= 1'b0;
      end else begin
        case (st)
          ST_PD: if (pd_n) begin
            st   <= ST_WAKE;
            wcnt <= WW'(WAKE_CYCLES);
          end
          ST_WAKE: if (wcnt <= WW'(1)) begin
            st         <= ST_ACT;
            abort_pend <= 1'b0;
          end else begin
            wcnt <= wcnt - 1'b1;
          end
          default: begin
            if (op_busy) begin
              if (bcnt <= BW'(1)) begin
                op_busy  <= 1'b0;
                stat_rdy <= 1'b1;
              end else begin
                bcnt <= bcnt - 1'b1;
              end
            end
            if (cmd_ok) begin
              if (armed) begin
                armed    <= 1'b0;
                op_busy  <= 1'b1;
                bcnt     <= BW'(BUSY_CYCLES);
                stat_rdy <= 1'b0;
                mode     <= M_STAT;
              end else begin
                case (din)
                  8'hFF:   mode <= M_ARRAY;
                  8'h90:   mode <= M_ID;
                  8'h70:   mode <= M_STAT;
                  8'h40:   armed <= !op_busy;
                  default: ;
                endcase
              end
            end
          end
        endcase
      end
    end
  end

  // R8: power-down entry leaves no operation, array mode and ready status
  p_pd_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PD && $past(st) != ST_PD) |-> (!op_busy && mode == M_ARRAY && stat_rdy));

  // R9: mode is array read the whole time the device is not awake
  p_down_array_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_ACT) |-> (mode == M_ARRAY));

  // R9: ready only comes back once awake
  p_ready_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> (st == ST_ACT));

  // R7: a busy period always shows a cleared status bit 7
  p_busy_stat_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op_busy |-> !stat_rdy);

  // R7: an operation only starts after the setup command, in status mode
  p_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_busy) |-> ($past(armed) && mode == M_STAT));

endmodule

// File: tb/flash_bus_ctrl_test.sv
module flash_bus_ctrl_test;
  localparam int AW = 20, MINP = 5, WAKE = 8, BUSY = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, pd_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0, dout, mem_rdata;
  logic bus_drive, ready;
  logic [AW-1:0] mem_addr;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  always_ff @(posedge clk) mem_rdata <= mem_addr[7:0] ^ 8'hA5;

  flash_bus_ctrl #(.AW(AW), .MIN_PD(MINP), .WAKE_CYCLES(WAKE), .BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .pd_n(pd_n),
    .addr(addr), .din(din), .dout(dout), .bus_drive(bus_drive), .ready(ready),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk); ce_n = 1'b0; we_n = 1'b0; din = d;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d, output logic drv);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    @(negedge clk); d = dout; drv = bus_drive;
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic pd_pulse(input int n);
    @(negedge clk); pd_n = 1'b0;
    repeat (n) @(negedge clk);
    pd_n = 1'b1;
  endtask

  task automatic wait_ready;
    for (int i = 0; i < 100 && !ready; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d; logic drv;
    chk("R1 ready after reset", ready, 1);
    chk("R1 bus idle after reset", bus_drive, 0);
    chk("R3 dout zero when idle", dout, 0);
    rd(20'h5, d, drv);
    chk("R4 array read drive", drv, 1);
    chk("R4 array read data", d, 8'h05 ^ 8'hA5);
  endtask

  task automatic t_modes;
    logic [7:0] d; logic drv;
    wr(8'h90);
    rd(20'h0, d, drv); chk("R5 manufacturer code", d, 8'h5C);
    rd(20'h1, d, drv); chk("R5 device code", d, 8'h3E);
    rd(20'h2, d, drv); chk("R5 other id address", d, 8'h00);
    wr(8'h33);
    rd(20'h1, d, drv); chk("R10 unknown byte keeps mode", d, 8'h3E);
    wr(8'h70);
    rd(20'h9, d, drv); chk("R6 status idle", d, 8'h80);
    wr(8'hFF);
    rd(20'h7, d, drv); chk("R2 back to array", d, 8'h07 ^ 8'hA5);
    @(negedge clk); ce_n = 1'b1; we_n = 1'b0; din = 8'h90;
    @(negedge clk); we_n = 1'b1;
    @(negedge clk);
    rd(20'h0, d, drv); chk("R2 deselected write ignored", d, 8'hA5);
  endtask

  task automatic t_gating;
    @(negedge clk); addr = 20'h3; ce_n = 1'b0; oe_n = 1'b1;
    #2 chk("R3 oe high no drive", bus_drive, 0);
    chk("R3 oe high dout zero", dout, 0);
    ce_n = 1'b1; oe_n = 1'b0;
    #2 chk("R3 ce high no drive", bus_drive, 0);
    ce_n = 1'b0; we_n = 1'b0;
    #2 chk("R3 we low no drive", bus_drive, 0);
    ce_n = 1'b1;
    @(negedge clk); we_n = 1'b1; ce_n = 1'b0; pd_n = 1'b0;
    #2 chk("R3 pd low no drive", bus_drive, 0);
    @(negedge clk); pd_n = 1'b1;
    #2 chk("R3 drive restored", bus_drive, 1);
    ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic t_busy;
    logic [7:0] d; logic drv; int n;
    wr(8'h40); wr(8'h12);
    chk("R7 ready low at start", ready, 0);
    n = 0;
    for (int i = 0; i < 100 && !ready; i++) begin @(negedge clk); n++; end
    chk("R7 busy length", n, BUSY);
    wr(8'h40); wr(8'h12);
    rd(20'h0, d, drv); chk("R7 status during busy", d, 8'h00);
    wr(8'h40); wr(8'h12);
    wait_ready();
    n = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (!ready) n++; end
    chk("R7 setup while busy ignored", n, 0);
    rd(20'h0, d, drv); chk("R7 status after busy", d, 8'h80);
  endtask

  task automatic t_short_pd;
    logic [7:0] d; logic drv;
    wr(8'h40); wr(8'h55);
    pd_pulse(MINP - 1);
    @(negedge clk);
    chk("R8 short pulse keeps op", ready, 0);
    wait_ready();
    rd(20'h0, d, drv); chk("R8 short pulse keeps mode", d, 8'h80);
  endtask

  task automatic t_long_pd;
    logic [7:0] d; logic drv; int n; logic bad;
    wr(8'h40); wr(8'h66);
    pd_pulse(MINP + 3);
    chk("R8 abort holds ready low", ready, 0);
    addr = 20'h4; ce_n = 1'b0; oe_n = 1'b0;
    n = 0; bad = 1'b0;
    for (int i = 0; i < 100 && !ready; i++) begin
      @(negedge clk); n++;
      if (!ready && bus_drive) bad = 1'b1;
    end
    chk("R9 no drive during wake", bad, 0);
    chk("R9 wake length", n, WAKE + 1);
    chk("R9 drive after wake", bus_drive, 1);
    chk("R8 array mode after abort", dout, 8'h04 ^ 8'hA5);
    ce_n = 1'b1; oe_n = 1'b1;
    wr(8'h70);
    rd(20'h0, d, drv); chk("R8 status 80h after abort", d, 8'h80);
  endtask

  task automatic t_pd_mode;
    logic [7:0] d; logic drv;
    wr(8'h90);
    pd_pulse(MINP);
    repeat (WAKE + 3) @(negedge clk);
    chk("R9 ready with no aborted op", ready, 1);
    rd(20'h0, d, drv); chk("R8 exact minimum pulse resets mode", d, 8'hA5);
    pd_pulse(MINP);
    wr(8'h90);
    repeat (WAKE + 3) @(negedge clk);
    rd(20'h0, d, drv); chk("R9 command in wake ignored", d, 8'hA5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_modes();
    t_gating();
    t_busy();
    t_short_pd();
    t_long_pd();
    t_pd_mode();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 100000);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule